// File: doc/BRIEF.md
# Shared Byte FIFO with Register and DMA Access

This block holds up to sixteen bytes of bus data in flight between a processor and a DMA engine. The processor reaches the oldest stored byte through a single register select. The DMA engine reaches the same byte through an acknowledge line qualified by a read or write strobe. Both ports share one storage array, one pair of pointers and one occupancy counter. In any cycle only one access is carried out, and the DMA side has priority.

The read data is the oldest entry, presented combinationally. A read removes that entry at the clock edge that ends the access. The block exports the occupancy, empty and full flags, and three sticky error flags: overflow, underflow and port collision.

Four separate events empty the FIFO: the active-low hardware reset, a software reset pulse, the start of a selection or reselection sequence, and a clear command pulse. An emptied FIFO drives zero on its read data.

The occupancy controller is a state machine with three states:
- OCC_EMPTY goes to OCC_PART on an accepted write, or straight to OCC_FULL when the depth is one.
- OCC_PART goes to OCC_FULL on a write that fills the last slot.
- OCC_PART goes to OCC_EMPTY on a read that removes the last entry.
- OCC_FULL goes to OCC_PART on a read, or to OCC_EMPTY when the depth is one.
- Any clear event sends every state to OCC_EMPTY.

Top module: `bfifo_dual_port`

## Requirements
- R1: While and after hardware reset (rst_n low), level is 0, is_empty is 1, is_full is 0, rd_data is 0 and all sticky flags are 0.
- R2: With host_sel high, host_wr performs a write of host_wdata. host_rd alone performs a read. Entries leave in the order they were written. A read shows the oldest entry on rd_data in the same cycle, and that entry is removed at the closing clock edge.
- R3: The DMA port performs an access only while dma_ack is high together with dma_rd or dma_wr. Strobes without dma_ack change nothing.
- R4: The depth is 16 entries of 8 bits. level counts stored entries from 0 to 16. is_empty is high exactly when level is 0, and is_full is high exactly when level is 16.
- R5: A write while full is dropped, leaves level and contents unchanged, and sets the sticky overflow flag.
- R6: A read while empty shows 0 on rd_data, leaves level at 0, and sets the sticky underflow flag.
- R7: If host and DMA both request in one cycle, only the DMA access is carried out and the sticky collision flag is set.
- R8: A pulse on soft_rst, sel_start or clr_cmd has the same effect. At the next edge it empties the FIFO, forces rd_data to 0 and clears all three sticky flags. Any access in that cycle is ignored.
- R9: A port that asserts both its read and write strobes performs a write only.
- R10: Host strobes are ignored while host_sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset pulse, empties FIFO |
| sel_start | input | 1 | Selection/reselection sequence start, empties FIFO |
| clr_cmd | input | 1 | Clear command pulse, empties FIFO |
| host_sel | input | 1 | Host register select for the FIFO address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| dma_ack | input | 1 | DMA acknowledge |
| dma_rd | input | 1 | DMA read strobe |
| dma_wr | input | 1 | DMA write strobe |
| dma_wdata | input | 8 | DMA write data |
| rd_data | output | 8 | Oldest entry, 0 when empty |
| level | output | 5 | Number of stored entries |
| is_empty | output | 1 | FIFO empty |
| is_full | output | 1 | FIFO full |
| overflow | output | 1 | Sticky: write dropped while full |
| underflow | output | 1 | Sticky: read while empty |
| collision | output | 1 | Sticky: host access lost to DMA |

## Verification
The FIFO is filled to all sixteen entries with writes that alternate between the two ports, then drained with reads that alternate the other way. Byte ordering and occupancy are checked at every step, which shows that the ports really share one array. Each of the three clear pulses is applied at every fill level from 0 to 16 while a write is also offered. This separates a true empty-and-zero from a partial pointer reset, and shows that accesses in the clear cycle are ignored. Single-cycle patterns then probe the cases that gating errors would pass through: strobes without acknowledge or select, both strobes at once, simultaneous port requests, and accesses at the full and empty boundaries.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;
endpackage

// File: rtl/bfifo_arb.sv
module bfifo_arb
    import bfifo_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         host_sel,
    input  logic         host_rd,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         dma_ack,
    input  logic         dma_rd,
    input  logic         dma_wr,
    input  logic [W-1:0] dma_wdata,
    output op_e          op,
    output logic [W-1:0] op_wdata,
    output logic         clash
);
    logic host_req;
    logic dma_req;

    always_comb begin
        host_req = host_sel && (host_rd || host_wr);
        dma_req  = dma_ack && (dma_rd || dma_wr);
        op       = OP_NONE;
        op_wdata = '0;
        if (dma_req) begin
            op       = dma_wr ? OP_WRITE : OP_READ;
            op_wdata = dma_wdata;
        end else if (host_req) begin
            op       = host_wr ? OP_WRITE : OP_READ;
            op_wdata = host_wdata;
        end
        clash = host_req && dma_req;
    end
endmodule

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
    import bfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_any,
    input  op_e           op,
    input  logic          clash,
    output logic          wr_en,
    output logic          rd_en,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          overflow,
    output logic          underflow,
    output logic          collision
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    occ_e          state_q, state_d;
    logic [CW-1:0] count_q;
    logic          ovf_q, udf_q, col_q;
    logic          ovf_evt, udf_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clr_any) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY: if (wr_en) state_d = (count_q == LAST_CNT) ? OCC_FULL : OCC_PART;
                OCC_PART: begin
                    if (wr_en && count_q == LAST_CNT)     state_d = OCC_FULL;
                    else if (rd_en && count_q == ONE_CNT) state_d = OCC_EMPTY;
                end
                OCC_FULL:  if (rd_en) state_d = (count_q == ONE_CNT) ? OCC_EMPTY : OCC_PART;
                default:   state_d = OCC_EMPTY;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        empty   = (state_q == OCC_EMPTY);
        full    = (state_q == OCC_FULL);
        wr_en   = !clr_any && (op == OP_WRITE) && !full;
        rd_en   = !clr_any && (op == OP_READ) && !empty;
        ovf_evt = !clr_any && (op == OP_WRITE) && full;
        udf_evt = !clr_any && (op == OP_READ) && empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
            col_q   <= 1'b0;
        end else if (clr_any) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
            col_q   <= 1'b0;
        end else begin
            if (wr_en)      count_q <= count_q + ONE_CNT;
            else if (rd_en) count_q <= count_q - ONE_CNT;
            if (ovf_evt) ovf_q <= 1'b1;
            if (udf_evt) udf_q <= 1'b1;
            if (clash)   col_q <= 1'b1;
        end
    end

    assign count     = count_q;
    assign overflow  = ovf_q;
    assign underflow = udf_q;
    assign collision = col_q;

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) count_q <= FULL_CNT); // R4
    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n) full == (count_q == FULL_CNT)); // R4
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) empty == (count_q == '0)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && op == OP_WRITE && !clr_any) |=> (full && $stable(count_q) && ovf_q)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && op == OP_READ && !clr_any) |=> (empty && udf_q)); // R6
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (empty && !ovf_q && !udf_q && !col_q)); // R8
endmodule

// File: rtl/bfifo_store.sv
module bfifo_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_any,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    input  logic         empty,
    output logic [W-1:0] rdata
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr_any) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + AW'(1);
            if (rd_en) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + AW'(1);
        end
    end

    assign rdata = empty ? '0 : mem[rd_ptr];

    AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (wr_ptr == rd_ptr)); // R8
endmodule

// File: rtl/bfifo_dual_port.sv
module bfifo_dual_port
    import bfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          sel_start,
    input  logic          clr_cmd,
    input  logic          host_sel,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          dma_ack,
    input  logic          dma_rd,
    input  logic          dma_wr,
    input  logic [W-1:0]  dma_wdata,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] level,
    output logic          is_empty,
    output logic          is_full,
    output logic          overflow,
    output logic          underflow,
    output logic          collision
);
    op_e          op;
    logic [W-1:0] op_wdata;
    logic         clash;
    logic         clr_any;
    logic         wr_en, rd_en;

    assign clr_any = soft_rst || sel_start || clr_cmd;

    bfifo_arb #(.W(W)) u_arb (
        .host_sel   (host_sel),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .dma_ack    (dma_ack),
        .dma_rd     (dma_rd),
        .dma_wr     (dma_wr),
        .dma_wdata  (dma_wdata),
        .op         (op),
        .op_wdata   (op_wdata),
        .clash      (clash)
    );

    bfifo_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_any   (clr_any),
        .op        (op),
        .clash     (clash),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .count     (level),
        .empty     (is_empty),
        .full      (is_full),
        .overflow  (overflow),
        .underflow (underflow),
        .collision (collision)
    );

    bfifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_any (clr_any),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (op_wdata),
        .empty   (is_empty),
        .rdata   (rd_data)
    );

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty |-> (rd_data == '0)); // R6
    AST_DMA_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && (host_rd || host_wr) && dma_ack && (dma_rd || dma_wr) && !clr_any)
        |=> collision); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (rd_data == '0 && level == '0)); // R8
endmodule

// File: tb/tb_bfifo_dual_port.sv
`timescale 1ns/1ps
module tb_bfifo_dual_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       soft_rst, sel_start, clr_cmd;
    logic       host_sel, host_rd, host_wr;
    logic [7:0] host_wdata;
    logic       dma_ack, dma_rd, dma_wr;
    logic [7:0] dma_wdata;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       is_empty, is_full, overflow, underflow, collision;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int mq [16];
    int mcnt = 0;
    int movf = 0, mudf = 0, mcol = 0;

    always #4 clk = ~clk;

    bfifo_dual_port dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel_start(sel_start), .clr_cmd(clr_cmd),
        .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .dma_ack(dma_ack), .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
        .rd_data(rd_data), .level(level), .is_empty(is_empty), .is_full(is_full),
        .overflow(overflow), .underflow(underflow), .collision(collision)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_op(input bit wr, input int d);
        if (wr) begin
            if (mcnt == 16) movf = 1;
            else begin mq[mcnt] = d; mcnt++; end
        end else begin
            if (mcnt == 0) mudf = 1;
            else begin
                for (int k = 0; k < 15; k++) mq[k] = mq[k+1];
                mcnt--;
            end
        end
    endtask

    task automatic step(input bit hs, input bit hr, input bit hw, input int hd,
                        input bit da, input bit dr, input bit dw, input int dd,
                        input bit sr, input bit ss, input bit cc, input string tag);
        bit hreq, dreq, clr;
        @(negedge clk);
        host_sel = hs; host_rd = hr; host_wr = hw; host_wdata = 8'(hd);
        dma_ack = da; dma_rd = dr; dma_wr = dw; dma_wdata = 8'(dd);
        soft_rst = sr; sel_start = ss; clr_cmd = cc;
        #2;
        chk({tag, " rd_data"}, int'(rd_data), (mcnt > 0) ? mq[0] : 0);
        hreq = hs && (hr || hw);
        dreq = da && (dr || dw);
        clr  = sr || ss || cc;
        if (clr) begin
            mcnt = 0; movf = 0; mudf = 0; mcol = 0;
        end else if (dreq) begin
            model_op(dw, dd);
            if (hreq) mcol = 1;
        end else if (hreq) begin
            model_op(hw, hd);
        end
        @(posedge clk);
        #1;
        host_sel = 0; host_rd = 0; host_wr = 0; dma_ack = 0; dma_rd = 0; dma_wr = 0;
        soft_rst = 0; sel_start = 0; clr_cmd = 0;
        chk({tag, " level"}, int'(level), mcnt);
        chk("R4 is_empty", int'(is_empty), int'(mcnt == 0));
        chk("R4 is_full", int'(is_full), int'(mcnt == 16));
        chk("R5 overflow", int'(overflow), movf);
        chk("R6 underflow", int'(underflow), mudf);
        chk("R7 collision", int'(collision), mcol);
    endtask

    task automatic hwrite(input int d, input string tag); step(1,0,1,d, 0,0,0,0, 0,0,0, tag); endtask
    task automatic hread(input string tag);               step(1,1,0,0, 0,0,0,0, 0,0,0, tag); endtask
    task automatic dwrite(input int d, input string tag); step(0,0,0,0, 1,0,1,d, 0,0,0, tag); endtask
    task automatic dread(input string tag);               step(0,0,0,0, 1,1,0,0, 0,0,0, tag); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        soft_rst = 0; sel_start = 0; clr_cmd = 0;
        host_sel = 0; host_rd = 0; host_wr = 0; host_wdata = 0;
        dma_ack = 0; dma_rd = 0; dma_wr = 0; dma_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 level", int'(level), 0);
        chk("R1 is_empty", int'(is_empty), 1);
        chk("R1 is_full", int'(is_full), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 flags", int'({overflow, underflow, collision}), 0);
        rst_n = 1;

        // R2 R3 R4: fill with alternating ports, order checked during drain
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 0) hwrite((i * 37 + 5) & 255, "R2 fill");
            else            dwrite((i * 37 + 5) & 255, "R3 fill");
        end
        // R5: writes while full from both ports
        hwrite(8'h11, "R5 host full");
        dwrite(8'h22, "R5 dma full");
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 0) dread("R3 drain");
            else            hread("R2 drain");
        end
        // R6: reads while empty
        hread("R6 host empty");
        dread("R6 dma empty");

        hwrite(8'hA1, "R2 setup");
        hwrite(8'hB2, "R2 setup");
        // R3: DMA strobes without acknowledge ignored
        step(0,0,0,0, 0,1,0,8'h33, 0,0,0, "R3 no ack rd");
        step(0,0,0,0, 0,0,1,8'h44, 0,0,0, "R3 no ack wr");
        // R10: host strobes without select ignored
        step(0,1,0,0, 0,0,0,0, 0,0,0, "R10 no sel rd");
        step(0,0,1,8'h55, 0,0,0,0, 0,0,0, "R10 no sel wr");
        // R9: both strobes means write
        step(1,1,1,8'hC3, 0,0,0,0, 0,0,0, "R9 host both");
        step(0,0,0,0, 1,1,1,8'hD4, 0,0,0, "R9 dma both");
        // R7: collisions
        step(1,0,1,8'hAA, 1,0,1,8'h5A, 0,0,0, "R7 both write");
        step(1,0,1,8'hEE, 1,1,0,0, 0,0,0, "R7 host wr dma rd");
        for (int i = 0; i < 5; i++) hread("R7 drain");

        // R8: each clear source at every fill level, with a write offered in the clear cycle
        for (int kind = 0; kind < 3; kind++) begin
            for (int n = 0; n <= 16; n++) begin
                for (int i = 0; i < n; i++) hwrite((n * 11 + i * 3 + kind) & 255, "R8 load");
                if (n == 0)  hread("R8 set underflow");
                if (n == 16) dwrite(8'h77, "R8 set overflow");
                step(1,0,1,8'h99, 1,0,1,8'h66, kind == 0, kind == 1, kind == 2, "R8 clear");
                chk("R8 rd_data after clear", int'(rd_data), 0);
            end
        end
        hwrite(8'h3C, "R8 after clear");
        hread("R8 after clear");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule